// File: doc/BRIEF.md
# Register-Programmed PWM Timer Channel

This block is a single pulse-width-modulated output driven by a free-running power-of-two prescaler and a 10-bit period counter. Software programs it through two 32-bit words on a simple register bus. The control word at offset 0x00 holds the run enable, a staging bit and the prescaler selection. The counter word at offset 0x04 holds the period length and the active (high) length, both counted in divided-clock ticks.

The prescaler exponent n (0..24) is split across two fields. A single mode bit carries bit 0 of n. A 4-bit field carries n shifted right by one. The block decodes the two back into n. Period, active length and exponent are staged in shadow registers. While the staging bit is set, writes land only in the shadows. Once it is clear, the whole set commits together at the end of the running period, or at once when the channel is not running. Period and duty therefore never change halfway through a period.

Top module: `pwmt_channel`

## Requirements
- R1: After reset both words read as zero and the output is low.
- R2: Only defined bits read back: bit 0 (enable), bit 11 (staging), bit 15 (mode), bits 19:16 (divider field) of the control word, and bits 25:16 (period) and 9:0 (active length) of the counter word. Every other bit reads 0, and read data is 0 while read enable is low.
- R3: The tick interval is 2^n input clocks, where n = 2*divider field + mode bit. Any encoded n above the largest supported exponent acts as that largest exponent.
- R4: A running period lasts period-length ticks. The output is high for the first active-length ticks and low for the rest.
- R5: When the active length is equal to or greater than the period length, the output stays high continuously.
- R6: A period length or active length of zero keeps the output low, even with enable set.
- R7: Clearing enable drives the output low in the cycle after the write. Setting it again starts a fresh period at tick zero.
- R8: While the staging bit is 1, writes to the period, active length and exponent do not alter the output, although reads return the newly written values. After the write that clears the staging bit, the new set takes effect at the first period boundary that follows that write.
- R9: When the channel is not running, a staged set commits as soon as the staging bit is clear, so the first period after enable already uses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address; bits above 1 select the word |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| pwm_o | output | 1 | PWM output |

## Verification
Two events can land on the same edge: a write that clears the staging bit, and the period boundary that would commit shadow contents. The bench waits zero to three extra cycles before clearing the staging bit against a period of four ticks. This places the clearing write on each phase of the period, including exactly on the boundary edge. For each run the bench computes the first boundary strictly after that write. It then checks, cycle by cycle, that the old waveform continues up to that boundary and the new one starts from tick zero there.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned SYNC_BIT = 11;
  localparam int unsigned MODE_BIT = 15;
  localparam int unsigned DIVF_LSB = 16;
  localparam int unsigned DIVF_W   = 4;
  localparam int unsigned PER_LSB  = 16;
  localparam int unsigned ACT_LSB  = 0;

  // Rebuild the prescaler exponent from its split encoding, saturating.
  function automatic int unsigned exp_decode(input logic mode,
                                             input logic [DIVF_W-1:0] divf,
                                             input int unsigned exp_max);
    int unsigned raw;
    raw = 32'({divf, mode});
    return (raw > exp_max) ? exp_max : raw;
  endfunction

  // Low-order mask of 2^n - 1 for an n-bit tick window.
  function automatic logic [31:0] tick_mask(input int unsigned n);
    logic [32:0] one_hot;
    one_hot = 33'(1) << n;
    return 32'(one_hot - 33'(1));
  endfunction

endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs
  import pwmt_pkg::*;
#(
  parameter int unsigned CNT_W   = 10,
  parameter int unsigned EXP_MAX = 24,
  parameter int unsigned ADDR_W  = 3,
  localparam int unsigned EXP_W  = $clog2(EXP_MAX + 1),
  localparam int unsigned IDX_W  = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  input  logic              run,
  input  logic              period_end,
  output logic              en_q,
  output logic              sync_q,
  output logic              xfer,
  output logic [CNT_W-1:0]  act_cyc,
  output logic [CNT_W-1:0]  act_ph,
  output logic [EXP_W-1:0]  act_exp
);

  logic [IDX_W-1:0]  widx;
  logic              sel_ctrl, sel_cnt;
  logic              nxt_sync, stage_req, pending;
  logic              sh_mode;
  logic [DIVF_W-1:0] sh_divf;
  logic [CNT_W-1:0]  sh_cyc, sh_ph;
  logic              unused_wbits;

  assign widx     = bus_addr[ADDR_W-1:2];
  assign sel_ctrl = (widx == IDX_W'(0));
  assign sel_cnt  = (widx == IDX_W'(1));
  assign unused_wbits = ^{bus_wdata, bus_addr[1:0]};

  // A write that leaves the staging bit clear arms a commit.
  assign nxt_sync  = (bus_we && sel_ctrl) ? bus_wdata[SYNC_BIT] : sync_q;
  assign stage_req = bus_we && (sel_ctrl || sel_cnt) && !nxt_sync;
  assign xfer      = pending && !sync_q && (!run || period_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      sync_q  <= 1'b0;
      sh_mode <= 1'b0;
      sh_divf <= '0;
      sh_cyc  <= '0;
      sh_ph   <= '0;
      act_cyc <= '0;
      act_ph  <= '0;
      act_exp <= '0;
      pending <= 1'b0;
    end else begin
      if (bus_we && sel_ctrl) begin
        en_q    <= bus_wdata[EN_BIT];
        sync_q  <= bus_wdata[SYNC_BIT];
        sh_mode <= bus_wdata[MODE_BIT];
        sh_divf <= bus_wdata[DIVF_LSB +: DIVF_W];
      end
      if (bus_we && sel_cnt) begin
        sh_cyc <= bus_wdata[PER_LSB +: CNT_W];
        sh_ph  <= bus_wdata[ACT_LSB +: CNT_W];
      end
      if (xfer) begin
        act_cyc <= sh_cyc;
        act_ph  <= sh_ph;
        act_exp <= EXP_W'(exp_decode(sh_mode, sh_divf, EXP_MAX));
      end
      if (stage_req)
        pending <= 1'b1;
      else if (xfer)
        pending <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_re && sel_ctrl) begin
      bus_rdata[EN_BIT]                 = en_q;
      bus_rdata[SYNC_BIT]               = sync_q;
      bus_rdata[MODE_BIT]               = sh_mode;
      bus_rdata[DIVF_LSB +: DIVF_W]     = sh_divf;
    end else if (bus_re && sel_cnt) begin
      bus_rdata[PER_LSB +: CNT_W]       = sh_cyc;
      bus_rdata[ACT_LSB +: CNT_W]       = sh_ph;
    end
  end

endmodule

// File: rtl/pwmt_prescale.sv
module pwmt_prescale
  import pwmt_pkg::*;
#(
  parameter int unsigned EXP_MAX = 24,
  localparam int unsigned EXP_W  = $clog2(EXP_MAX + 1),
  localparam int unsigned PRE_W  = (EXP_MAX < 1) ? 1 : EXP_MAX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [EXP_W-1:0] exp_n,
  output logic             tick
);

  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] mask;
  logic [31:0]      mask_full;
  logic             unused_mask;

  assign mask_full   = tick_mask(32'(exp_n));
  assign mask        = mask_full[PRE_W-1:0];
  assign unused_mask = ^mask_full;
  assign tick        = run && ((cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || restart)
      cnt <= '0;
    else
      cnt <= cnt + PRE_W'(1);
  end

endmodule

// File: rtl/pwmt_period.sv
module pwmt_period #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] cyc,
  input  logic [CNT_W-1:0] ph,
  output logic [CNT_W-1:0] pos,
  output logic             period_end,
  output logic             pwm
);

  logic last;

  assign last       = (pos >= cyc - CNT_W'(1));
  assign period_end = run && tick && last;
  assign pwm        = run && (pos < ph);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || restart)
      pos <= '0;
    else if (tick)
      pos <= last ? '0 : pos + CNT_W'(1);
  end

endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
  import pwmt_pkg::*;
#(
  parameter int unsigned CNT_W   = 10,
  parameter int unsigned EXP_MAX = 24,
  parameter int unsigned ADDR_W  = 3,
  localparam int unsigned EXP_W  = $clog2(EXP_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  output logic              pwm_o
);

  logic             en_q, sync_q, xfer, run, tick, period_end;
  logic [CNT_W-1:0] act_cyc, act_ph, pos;
  logic [EXP_W-1:0] act_exp;

  assign run = en_q && (act_cyc != '0) && (act_ph != '0);

  pwmt_regs #(.CNT_W(CNT_W), .EXP_MAX(EXP_MAX), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .run(run), .period_end(period_end), .en_q(en_q), .sync_q(sync_q),
    .xfer(xfer), .act_cyc(act_cyc), .act_ph(act_ph), .act_exp(act_exp)
  );

  pwmt_prescale #(.EXP_MAX(EXP_MAX)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(xfer),
    .exp_n(act_exp), .tick(tick)
  );

  pwmt_period #(.CNT_W(CNT_W)) u_per (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(xfer), .tick(tick),
    .cyc(act_cyc), .ph(act_ph), .pos(pos), .period_end(period_end),
    .pwm(pwm_o)
  );

endmodule

// File: rtl/pwmt_check.sv
module pwmt_check #(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned EXP_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic             sync_q,
  input logic             run,
  input logic             tick,
  input logic             period_end,
  input logic [CNT_W-1:0] act_cyc,
  input logic [CNT_W-1:0] act_ph,
  input logic [EXP_W-1:0] act_exp,
  input logic [CNT_W-1:0] pos,
  input logic             pwm_o
);

  p_unit_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && act_exp == '0) |-> tick);

  p_pos_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pos < act_cyc));

  p_full_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && act_ph >= act_cyc) |-> pwm_o);

  p_zero_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_cyc == '0 || act_ph == '0) |-> !pwm_o);

  p_off_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !pwm_o);

  p_sync_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |=> ($stable(act_cyc) && $stable(act_ph) && $stable(act_exp)));

  p_commit_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !($stable(act_cyc) && $stable(act_ph) && $stable(act_exp)))
      |-> $past(period_end));

endmodule

bind pwmt_channel pwmt_check #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .sync_q(sync_q), .run(run),
  .tick(tick), .period_end(period_end), .act_cyc(act_cyc), .act_ph(act_ph),
  .act_exp(act_exp), .pos(pos), .pwm_o(pwm_o)
);

// File: tb/pwmt_channel_test.sv
module pwmt_channel_test;

  localparam int EMAX = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        pwm_o;

  int edges = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) edges <= edges + 1;

  pwmt_channel #(.CNT_W(10), .EXP_MAX(EMAX), .ADDR_W(3)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pwm_o(pwm_o)
  );

  function automatic logic [31:0] ctl(int nf, bit en, bit sy);
    return (32'(nf >> 1) << 16) | (32'(nf & 1) << 15) | (32'(sy) << 11) | 32'(en);
  endfunction

  function automatic logic [31:0] cnt(int c, int p);
    return (32'(c) << 16) | 32'(p);
  endfunction

  function automatic bit wave(int k, int n, int c, int p);
    if (c == 0 || p == 0) return 1'b0;
    return ((k >> n) % c) < p;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a negedge; the write lands on the next posedge; returns at a negedge.
  task automatic wr(logic [2:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    bus_addr = a; bus_re = 1'b1;
    #1 v = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic run_wave(int n, int c, int p, int start, int len, string tag);
    bit bad = 0;
    bit a0 = 0, e0 = 0;
    for (int i = 0; i < len; i++) begin
      bit e;
      e = wave(edges - start, n, c, p);
      if (pwm_o !== e && !bad) begin bad = 1; a0 = pwm_o; e0 = e; end
      @(negedge clk);
    end
    chk(!bad, tag, a0, e0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int st, s_edge, b_edge, ne;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'h0, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(3'h4, v); chk(v == 0, "R1 count", v, 0);
    chk(pwm_o == 1'b0, "R1 pwm", pwm_o, 0);

    // R2 readback masking
    wr(3'h0, 32'hFFFF_FFFF);
    rd(3'h0, v); chk(v == 32'h000F_8801, "R2 ctrl mask", v, 32'h000F_8801);
    wr(3'h4, 32'hFFFF_FFFF);
    rd(3'h4, v); chk(v == 32'h03FF_03FF, "R2 count mask", v, 32'h03FF_03FF);
    bus_addr = 3'h4; #1 chk(bus_rdata == 0, "R2 no read", bus_rdata, 0);
    wr(3'h0, 32'h0);

    // R3 R4 R5 R6 sweep: exponent field, period, active length
    for (int ix = 0; ix < 7; ix++) begin
      for (int c = 0; c < 5; c++) begin
        for (int p = 0; p < 6; p++) begin
          int nf, ne2, len;
          string tag;
          nf  = (ix == 6) ? 31 : ix;
          ne2 = (nf > EMAX) ? EMAX : nf;
          tag = (c == 0 || p == 0) ? "R6 zero field" :
                (p >= c) ? "R5 full high" :
                (nf >= EMAX) ? "R3 saturate" : "R4 waveform";
          wr(3'h0, 32'h0);
          wr(3'h4, cnt(c, p));
          wr(3'h0, ctl(nf, 0, 0));
          wr(3'h0, ctl(nf, 1, 0));
          st  = edges;
          len = (c == 0) ? 8 : (2 * c) << ne2;
          run_wave(ne2, c, p, st, len, tag);
        end
      end
    end
    rd(3'h0, v); chk(v == 32'h000F_8001, "R3 field readback", v, 32'h000F_8001);

    // R7 disable then restart
    wr(3'h0, 32'h0);
    wr(3'h4, cnt(4, 2));
    wr(3'h0, ctl(1, 0, 0));
    wr(3'h0, ctl(1, 1, 0));
    repeat (5) @(negedge clk);
    wr(3'h0, ctl(1, 0, 0));
    chk(pwm_o == 1'b0, "R7 off next cycle", pwm_o, 0);
    wr(3'h0, ctl(1, 1, 0));
    st = edges;
    run_wave(1, 4, 2, st, 24, "R7 restart");

    // R8 staged update, clearing write at every phase of the period
    for (int d = 0; d < 4; d++) begin
      bit bad = 0;
      bit a0 = 0, e0 = 0;
      wr(3'h0, 32'h0);
      wr(3'h4, cnt(4, 1));
      wr(3'h0, ctl(0, 0, 0));
      wr(3'h0, ctl(0, 1, 0));
      ne = edges;
      for (int i = 0; i < d; i++) begin
        if (pwm_o !== wave(edges - ne, 0, 4, 1) && !bad) begin bad = 1; a0 = pwm_o; end
        @(negedge clk);
      end
      wr(3'h0, ctl(0, 1, 1));
      wr(3'h4, cnt(6, 3));
      rd(3'h4, v); chk(v == cnt(6, 3), "R8 shadow read", v, cnt(6, 3));
      for (int i = 0; i < 9; i++) begin
        if (pwm_o !== wave(edges - ne, 0, 4, 1) && !bad) begin bad = 1; a0 = pwm_o; e0 = !pwm_o; end
        @(negedge clk);
      end
      wr(3'h0, ctl(0, 1, 0));
      s_edge = edges;
      b_edge = s_edge + 1;
      while ((b_edge - ne) % 4 != 0) b_edge++;
      for (int i = 0; i < 30; i++) begin
        bit e;
        e = (edges < b_edge) ? wave(edges - ne, 0, 4, 1) : wave(edges - b_edge, 0, 6, 3);
        if (pwm_o !== e && !bad) begin bad = 1; a0 = pwm_o; e0 = e; end
        @(negedge clk);
      end
      chk(!bad, $sformatf("R8 commit delay %0d", d), a0, e0);
    end

    // R9 staged set commits while stopped
    wr(3'h0, 32'h0);
    wr(3'h0, ctl(0, 0, 1));
    wr(3'h4, cnt(3, 1));
    chk(pwm_o == 1'b0, "R9 idle low", pwm_o, 0);
    wr(3'h0, ctl(0, 0, 0));
    wr(3'h0, ctl(0, 1, 0));
    st = edges;
    run_wave(0, 3, 1, st, 18, "R9 first period");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule